// File: doc/BRIEF.md
# Card Read Threshold Clock Gate

This block sits between the data path of a memory-card host and its 1024-word by 32-bit receive FIFO during block reads. Before each block of a multi-block read it decides whether the block may begin. When threshold mode is active, it waits until the FIFO has at least a programmed number of free words, so that a whole block always fits. This means the card clock never has to stop partway through a block. Whenever the FIFO reaches full during a transfer, it drops the card clock enable until a word has been drained.

The block also holds the read configuration: the threshold enable, the threshold in words, the block size in bytes and the DMA burst-size code. It raises a configuration-error flag when these values do not form a legal setup. Configuration writes that arrive while a transfer is in progress are dropped. A transfer is started by a one-cycle pulse that carries the block count. The controller then grants blocks one at a time and counts the data words of each block.

Top module: `rdthr_clkgate`

## Requirements
- R1: After synchronous reset, `card_clk_en` is 1, `blk_grant` is 0 and `cfg_err` is 0. The reset configuration is threshold off, threshold 0, block size 512 bytes and burst code 0.
- R2: `cfg_err` is 1 when the stored block size in bytes is zero or is not a multiple of four (bits [1:0] not zero). It is valid in the cycle after the write edge.
- R3: The burst code stores the transfer count minus one. Only the codes 0, 3, 7, 15, 31, 63, 127 and 255 are legal. `cfg_err` is 1 for any other code, and also when the block size in words (bytes/4) is not an exact multiple of code+1.
- R4: When the block size in words exceeds 1024, the threshold enable is rejected. Blocks are then granted without a free-space check, and the threshold value raises no error.
- R5: With threshold mode in effect, `cfg_err` is 1 when the threshold is below the block size in words or above 1024.
- R6: With threshold mode in effect, free space (1024 minus `fifo_level`) is compared with the threshold and the result is registered. A waiting block is granted on the edge after the registered result is true, so `blk_grant` rises two edges after the level change that made room. While free space is below the threshold, no block is granted.
- R7: With threshold mode off, a waiting block is granted on the first edge after it starts waiting, whatever the fill level.
- R8: `blk_grant` is high for exactly one cycle per block. A transfer of N blocks yields N grants, and each block consumes block-size/4 `word_strobe` pulses. Start pulses are ignored while a transfer runs, while `cfg_err` is 1, or when the block count is 0.
- R9: `card_clk_en` is registered. It is 0 in the cycle after an edge at which a transfer is in progress and `fifo_level` is 1024, and it is 1 in the cycle after an edge at which the level is below 1024 or no transfer runs.
- R10: Configuration writes (`cfg_we`) during a transfer leave the stored configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the four configuration fields |
| cfg_thr_en | input | 1 | Threshold mode request |
| cfg_thr_words | input | 11 | Read threshold in 32-bit words |
| cfg_blk_bytes | input | 16 | Block size in bytes |
| cfg_burst_code | input | 8 | DMA burst transfer count minus one |
| fifo_level | input | 11 | Receive FIFO fill level in words (0 to 1024) |
| word_strobe | input | 1 | One data word written into the FIFO |
| xfer_start | input | 1 | Start-of-transfer pulse |
| xfer_nblk | input | 16 | Number of blocks, sampled with `xfer_start` |
| card_clk_en | output | 1 | Card clock enable |
| blk_grant | output | 1 | One-cycle grant to begin the next block |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The configuration error depends only on the stored fields. It is checked one edge after the write. The clock enable is checked one edge after each change of fill level or busy state. A block grant needs two edges from a level change: one for the registered compare and one for the grant register. With threshold mode off, it needs one edge after the block starts waiting. The bench samples two time units after each rising edge and places every check at the edge count above. Randomized configurations are compared against a bench function of the legality rules. Randomized threshold and level pairs are compared against the free-space rule.

// File: rtl/rdthr_pkg.sv
package rdthr_pkg;

    localparam int FIFO_DEPTH = 1024;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int BLKB_W     = 16;
    localparam int WRD_W      = BLKB_W - 2;
    localparam int BURST_W    = 8;
    localparam int NBLK_W     = 16;

    localparam logic [BLKB_W-1:0] RST_BLK_BYTES = BLKB_W'(512);

    typedef struct packed {
        logic               thr_en;
        logic [LVL_W-1:0]   thr;
        logic [BLKB_W-1:0]  blk_bytes;
        logic [BURST_W-1:0] burst_code;
    } rd_cfg_t;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_WAIT = 2'd1,
        XF_READ = 2'd2
    } xf_state_e;

    // Legal burst codes are a power of two minus one: 0,3,7,...,255.
    function automatic logic burst_code_ok(input logic [BURST_W-1:0] code);
        logic ok;
        ok = (code == '0);
        for (int k = 2; k <= BURST_W; k++) begin
            if (code == BURST_W'((1 << k) - 1)) ok = 1'b1;
        end
        return ok;
    endfunction

    function automatic logic [WRD_W-1:0] words_of(input logic [BLKB_W-1:0] nbytes);
        return nbytes[BLKB_W-1:2];
    endfunction

endpackage

// File: rtl/rdthr_cfg_regs.sv
module rdthr_cfg_regs
    import rdthr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  rd_cfg_t           cfg_in,
    input  logic              busy,
    output logic [LVL_W-1:0]  thr,
    output logic [WRD_W-1:0]  blk_words,
    output logic              thr_eff,
    output logic              cfg_err
);

    localparam logic [BLKB_W-1:0] DEPTH_B = BLKB_W'(FIFO_DEPTH);

    rd_cfg_t            cfg_q;
    logic [BLKB_W-1:0]  words_ext;
    logic [BLKB_W-1:0]  thr_ext;
    logic               size_bad;
    logic               burst_bad;
    logic               thr_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{thr_en: 1'b0, thr: '0, blk_bytes: RST_BLK_BYTES, burst_code: '0};
        end else if (cfg_we && !busy) begin
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        blk_words = words_of(cfg_q.blk_bytes);
        words_ext = BLKB_W'(blk_words);
        thr_ext   = BLKB_W'(cfg_q.thr);
        thr       = cfg_q.thr;
        thr_eff   = cfg_q.thr_en && (words_ext <= DEPTH_B);
        size_bad  = (cfg_q.blk_bytes[1:0] != 2'b00) || (blk_words == '0);
        burst_bad = !burst_code_ok(cfg_q.burst_code)
                    || ((words_ext & BLKB_W'(cfg_q.burst_code)) != '0);
        thr_bad   = thr_eff && ((thr_ext < words_ext) || (thr_ext > DEPTH_B));
        cfg_err   = size_bad || burst_bad || thr_bad;
    end

    // R10: a write during a transfer does not alter the stored fields
    assert_hold_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we) |=> $stable(cfg_q));

endmodule

// File: rtl/rdthr_space_cmp.sv
module rdthr_space_cmp
    import rdthr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  thr,
    input  logic              busy,
    output logic              room_ok,
    output logic              clk_en
);

    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

    logic [LVL_W-1:0] free_words;
    logic             full;

    always_comb begin
        free_words = DEPTH_L - fifo_level;
        full       = (fifo_level >= DEPTH_L);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            room_ok <= 1'b0;
            clk_en  <= 1'b1;
        end else begin
            room_ok <= (free_words >= thr);
            clk_en  <= !(busy && full);
        end
    end

    // R9: a full FIFO during a transfer stops the card clock on the next cycle
    assert_gate_full_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && (fifo_level >= DEPTH_L)) |=> !clk_en);

    // R9: with no transfer running the clock stays enabled
    assert_idle_clk_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |=> clk_en);

endmodule

// File: rtl/rdthr_xfer_fsm.sv
module rdthr_xfer_fsm
    import rdthr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic [NBLK_W-1:0] xfer_nblk,
    input  logic              word_strobe,
    input  logic [WRD_W-1:0]  blk_words,
    input  logic              thr_eff,
    input  logic              room_ok,
    input  logic              cfg_err,
    output logic              busy,
    output logic              blk_grant
);

    xf_state_e         state_q;
    logic [NBLK_W-1:0] left_q;
    logic [WRD_W-1:0]  wcnt_q;
    logic              go;
    logic              last_word;

    always_comb begin
        go        = !thr_eff || room_ok;
        last_word = (wcnt_q == blk_words - WRD_W'(1));
        busy      = (state_q != XF_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= XF_IDLE;
            left_q    <= '0;
            wcnt_q    <= '0;
            blk_grant <= 1'b0;
        end else begin
            blk_grant <= 1'b0;
            unique case (state_q)
                XF_IDLE: begin
                    if (xfer_start && !cfg_err && (xfer_nblk != '0)) begin
                        left_q  <= xfer_nblk;
                        state_q <= XF_WAIT;
                    end
                end
                XF_WAIT: begin
                    if (go) begin
                        blk_grant <= 1'b1;
                        wcnt_q    <= '0;
                        state_q   <= XF_READ;
                    end
                end
                XF_READ: begin
                    if (word_strobe) begin
                        if (last_word) begin
                            left_q  <= left_q - NBLK_W'(1);
                            state_q <= (left_q == NBLK_W'(1)) ? XF_IDLE : XF_WAIT;
                        end else begin
                            wcnt_q <= wcnt_q + WRD_W'(1);
                        end
                    end
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end

    // R8: each grant lasts a single cycle
    assert_grant_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        blk_grant |=> !blk_grant);

    // R8: a grant is only seen once the block is being read
    assert_grant_read_R8: assert property (@(posedge clk) disable iff (rst)
        blk_grant |-> (state_q == XF_READ));

    // R6: with threshold mode in effect a grant needs the registered room flag
    assert_grant_room_R6: assert property (@(posedge clk) disable iff (rst)
        (blk_grant && thr_eff) |-> $past(room_ok));

endmodule

// File: rtl/rdthr_clkgate.sv
module rdthr_clkgate
    import rdthr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_thr_en,
    input  logic [LVL_W-1:0]   cfg_thr_words,
    input  logic [BLKB_W-1:0]  cfg_blk_bytes,
    input  logic [BURST_W-1:0] cfg_burst_code,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic               word_strobe,
    input  logic               xfer_start,
    input  logic [NBLK_W-1:0]  xfer_nblk,
    output logic               card_clk_en,
    output logic               blk_grant,
    output logic               cfg_err
);

    rd_cfg_t           cfg_in;
    logic [LVL_W-1:0]  thr;
    logic [WRD_W-1:0]  blk_words;
    logic              thr_eff;
    logic              room_ok;
    logic              busy;

    always_comb begin
        cfg_in = '{thr_en: cfg_thr_en, thr: cfg_thr_words,
                   blk_bytes: cfg_blk_bytes, burst_code: cfg_burst_code};
    end

    rdthr_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_in    (cfg_in),
        .busy      (busy),
        .thr       (thr),
        .blk_words (blk_words),
        .thr_eff   (thr_eff),
        .cfg_err   (cfg_err)
    );

    rdthr_space_cmp u_space (
        .clk        (clk),
        .rst        (rst),
        .fifo_level (fifo_level),
        .thr        (thr),
        .busy       (busy),
        .room_ok    (room_ok),
        .clk_en     (card_clk_en)
    );

    rdthr_xfer_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .xfer_start  (xfer_start),
        .xfer_nblk   (xfer_nblk),
        .word_strobe (word_strobe),
        .blk_words   (blk_words),
        .thr_eff     (thr_eff),
        .room_ok     (room_ok),
        .cfg_err     (cfg_err),
        .busy        (busy),
        .blk_grant   (blk_grant)
    );

endmodule

// File: tb/rdthr_clkgate_tb_top.sv
module rdthr_clkgate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_thr_en = 1'b0;
    logic [10:0] cfg_thr_words = '0;
    logic [15:0] cfg_blk_bytes = 16'd512;
    logic [7:0]  cfg_burst_code = '0;
    logic [10:0] fifo_level = '0;
    logic        word_strobe = 1'b0;
    logic        xfer_start = 1'b0;
    logic [15:0] xfer_nblk = '0;
    logic        card_clk_en;
    logic        blk_grant;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rdthr_clkgate dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_thr_en     (cfg_thr_en),
        .cfg_thr_words  (cfg_thr_words),
        .cfg_blk_bytes  (cfg_blk_bytes),
        .cfg_burst_code (cfg_burst_code),
        .fifo_level     (fifo_level),
        .word_strobe    (word_strobe),
        .xfer_start     (xfer_start),
        .xfer_nblk      (xfer_nblk),
        .card_clk_en    (card_clk_en),
        .blk_grant      (blk_grant),
        .cfg_err        (cfg_err)
    );

    function automatic bit burst_ok(input int code);
        return code == 0 || code == 3 || code == 7 || code == 15 || code == 31
            || code == 63 || code == 127 || code == 255;
    endfunction

    function automatic bit exp_err(input bit en, input int thr, input int bytes, input int code);
        int  words;
        bit  eff;
        words = bytes / 4;
        eff = en && (words <= 1024);
        if ((bytes % 4) != 0 || words == 0) return 1'b1;
        if (!burst_ok(code)) return 1'b1;
        if ((words % (code + 1)) != 0) return 1'b1;
        if (eff && (thr < words || thr > 1024)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_cfg(input bit en, input int thr, input int bytes, input int code);
        cfg_thr_en     = en;
        cfg_thr_words  = 11'(thr);
        cfg_blk_bytes  = 16'(bytes);
        cfg_burst_code = 8'(code);
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic start(input int n);
        xfer_start = 1'b1;
        xfer_nblk  = 16'(n);
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic send_block(input int words, input string req);
        int g = 0;
        word_strobe = 1'b1;
        for (int i = 0; i < words; i++) begin
            tick();
            if (i < words - 1 && blk_grant) g++;
        end
        word_strobe = 1'b0;
        chk(g == 0, req, g, 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(card_clk_en == 1'b1, "R1 clk_en", card_clk_en, 1);
        chk(blk_grant == 1'b0, "R1 grant", blk_grant, 0);
        chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);

        // R7 threshold off: grant one edge after waiting starts
        wr_cfg(1'b0, 0, 512, 7);
        chk(cfg_err == 1'b0, "R3 legal code 7", cfg_err, 0);
        fifo_level = 11'd900;
        start(2);
        chk(blk_grant == 1'b0, "R7 no grant at start edge", blk_grant, 0);
        tick();
        chk(blk_grant == 1'b1, "R7 grant without space check", blk_grant, 1);
        tick();
        chk(blk_grant == 1'b0, "R8 grant one cycle", blk_grant, 0);
        send_block(128, "R8 no grant inside block");
        tick();
        chk(blk_grant == 1'b1, "R8 second block grant", blk_grant, 1);
        // R10: write of an illegal size during the transfer
        wr_cfg(1'b0, 0, 6, 0);
        chk(cfg_err == 1'b0, "R10 write during transfer dropped", cfg_err, 0);
        // R9 gating while busy
        fifo_level = 11'd1024;
        tick();
        chk(card_clk_en == 1'b0, "R9 full gates clock", card_clk_en, 0);
        fifo_level = 11'd1023;
        tick();
        chk(card_clk_en == 1'b1, "R9 clock back after drain", card_clk_en, 1);
        fifo_level = 11'd0;
        send_block(128, "R8 no grant inside last block");
        tick();
        chk(blk_grant == 1'b0, "R8 no grant after last block", blk_grant, 0);
        fifo_level = 11'd1024;
        tick();
        tick();
        chk(card_clk_en == 1'b1, "R9 idle keeps clock with full FIFO", card_clk_en, 1);
        chk(cfg_err == 1'b0, "R10 config unchanged after transfer", cfg_err, 0);

        // R6 threshold on
        wr_cfg(1'b1, 128, 512, 15);
        chk(cfg_err == 1'b0, "R5 threshold equal to block", cfg_err, 0);
        fifo_level = 11'd1000;
        start(1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(blk_grant == 1'b0, "R6 no grant with 24 free", blk_grant, 0);
        end
        fifo_level = 11'd897;
        tick();
        tick();
        chk(blk_grant == 1'b0, "R6 no grant with 127 free", blk_grant, 0);
        fifo_level = 11'd896;
        tick();
        chk(blk_grant == 1'b0, "R6 compare registered first", blk_grant, 0);
        tick();
        chk(blk_grant == 1'b1, "R6 grant with 128 free", blk_grant, 1);
        tick();
        chk(blk_grant == 1'b0, "R8 single grant", blk_grant, 0);
        send_block(128, "R8 no grant inside block");

        // R4 oversize block rejects the enable
        wr_cfg(1'b1, 8, 4100, 0);
        chk(cfg_err == 1'b0, "R4 threshold ignored for oversize block", cfg_err, 0);
        fifo_level = 11'd1024;
        start(1);
        tick();
        chk(blk_grant == 1'b1, "R4 grant with full FIFO", blk_grant, 1);
        chk(card_clk_en == 1'b0, "R9 gated while waiting full", card_clk_en, 0);
        fifo_level = 11'd0;
        send_block(1025, "R8 long block");
        tick();

        // R5 threshold bounds
        wr_cfg(1'b1, 100, 512, 0);
        chk(cfg_err == 1'b1, "R5 threshold below block", cfg_err, 1);
        wr_cfg(1'b1, 1025, 512, 0);
        chk(cfg_err == 1'b1, "R5 threshold above depth", cfg_err, 1);
        wr_cfg(1'b1, 1024, 512, 0);
        chk(cfg_err == 1'b0, "R5 threshold at depth", cfg_err, 0);

        // R2 block size
        wr_cfg(1'b0, 0, 514, 0);
        chk(cfg_err == 1'b1, "R2 size not multiple of four", cfg_err, 1);
        wr_cfg(1'b0, 0, 0, 0);
        chk(cfg_err == 1'b1, "R2 zero size", cfg_err, 1);
        wr_cfg(1'b0, 0, 4, 0);
        chk(cfg_err == 1'b0, "R2 four-byte size", cfg_err, 0);

        // R3 burst code
        wr_cfg(1'b0, 0, 512, 2);
        chk(cfg_err == 1'b1, "R3 illegal code 2", cfg_err, 1);
        wr_cfg(1'b0, 0, 48, 7);
        chk(cfg_err == 1'b1, "R3 12 words not divisible by 8", cfg_err, 1);
        wr_cfg(1'b0, 0, 48, 3);
        chk(cfg_err == 1'b0, "R3 12 words divisible by 4", cfg_err, 0);

        // R8 start refused on error or zero blocks
        wr_cfg(1'b0, 0, 514, 0);
        fifo_level = 11'd1024;
        start(1);
        tick();
        chk(blk_grant == 1'b0, "R8 start refused with cfg_err", blk_grant, 0);
        tick();
        chk(card_clk_en == 1'b1, "R8 not busy after refused start", card_clk_en, 1);
        wr_cfg(1'b0, 0, 512, 0);
        start(0);
        tick();
        chk(blk_grant == 1'b0, "R8 zero-block start refused", blk_grant, 0);
        tick();
        chk(card_clk_en == 1'b1, "R8 not busy after zero-block start", card_clk_en, 1);
        fifo_level = 11'd0;

        // R2 R3 R5: random configurations against the legality model
        for (int t = 0; t < 200; t++) begin
            bit en;
            int thr;
            int bytes;
            int code;
            en = 1'($urandom);
            thr = int'($urandom_range(0, 1100));
            bytes = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 5000))
                                                 : 4 * int'($urandom_range(1, 1100));
            code = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 255))
                                                : ((1 << $urandom_range(0, 8)) - 1);
            if (code == 1) code = 0;
            wr_cfg(en, thr, bytes, code);
            chk(cfg_err == exp_err(en, thr, bytes, code), "R2/R3/R5 random cfg_err",
                cfg_err, int'(exp_err(en, thr, bytes, code)));
        end

        // R6: random threshold and level pairs
        for (int t = 0; t < 40; t++) begin
            int thr;
            int lvl;
            bit exp_g;
            thr = int'($urandom_range(16, 1024));
            lvl = int'($urandom_range(0, 1024));
            exp_g = (1024 - lvl) >= thr;
            wr_cfg(1'b1, thr, 64, 3);
            fifo_level = 11'(lvl);
            start(1);
            tick();
            chk(blk_grant == exp_g, "R6 random free-space grant", blk_grant, int'(exp_g));
            if (!exp_g) begin
                fifo_level = 11'd0;
                tick();
                tick();
                chk(blk_grant == 1'b1, "R6 grant after drain", blk_grant, 1);
            end
            fifo_level = 11'd0;
            send_block(16, "R8 random block words");
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule